// File: doc/BRIEF.md
# SM3 Message Expansion Unit

This unit produces four consecutive expanded message words of the SM3 hash per operation. The work is split into two steps that share one set of lanes. A one-bit opcode picks between them. The preliminary step mixes the older words of the window and applies the P1 permutation. The final step combines those partial words with a second window and yields the next four schedule words.

Each operand and the result is a 128-bit bus of four 32-bit lanes. Lane i sits in bits [32i+31:32i], and lane 0 carries the lowest-indexed word. A request is taken on any cycle where `inValid` is high. The answer appears in a result register one cycle later, together with a one-cycle `outValid` pulse.

Software outside the unit walks the 68-word schedule. It must place the right window of earlier words into each operand.

Top module: `sm3_msg_expand`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `outValid` = 0 and `result` = 0.
- R2: `outValid` is high in exactly the cycle after each cycle in which `inValid` was high. Back-to-back requests give back-to-back pulses.
- R3: With `op` = 0, for lanes j = 0..2: `result` lane j = P1(`opA`[j] ^ `opC`[j] ^ rotl(`opB`[j],15)), where P1(x) = x ^ rotl(x,15) ^ rotl(x,23). Lane j is bits [32j+31:32j].
- R4: With `op` = 0, `result` lane 3 = P1(`opA`[3] ^ `opC`[3]). It has no rotated term.
- R5: With `op` = 0, `opB` lane 3 (bits [127:96]) has no effect on any lane of the result.
- R6: With `op` = 1, for lanes j = 0..2: `result` lane j = rotl(`opB`[j],7) ^ `opC`[j] ^ `opA`[j].
- R7: With `op` = 1, lane 3 first forms rotl(`opB`[3],7) ^ `opC`[3] ^ `opA`[3]. That value is then XORed with rotl(L0,6), rotl(L0,15) and rotl(L0,30), where L0 is the lane-0 result of the same operation.
- R8: In cycles after which `inValid` was low, `result` keeps its previous value, whatever the operands and opcode do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe; operands sampled at this edge |
| op | input | 1 | 0 = preliminary step, 1 = final step |
| opA | input | 128 | Operand A, four 32-bit lanes |
| opB | input | 128 | Operand B, four 32-bit lanes |
| opC | input | 128 | Operand C, four 32-bit lanes |
| outValid | output | 1 | One-cycle pulse marking a fresh result |
| result | output | 128 | Registered four-lane result |

## Verification
The bench drives both steps with pseudo-random operands and with patterns that light only one operand. This exposes a lane that takes its word from the wrong bus, or that rotates by the wrong amount.

It repeats preliminary requests that differ only in `opB` lane 3. A design that let that lane leak, or that gave lane 3 a rotated term, would return two different answers.

It gives the final step inputs where lane 0 is non-zero and lane 3 is zero. A missing or misrotated fix-up then shows as a wrong top lane.

Back-to-back requests, followed by idle cycles with operands still moving, catch a result register that reloads without a request and a valid pulse that stretches or drops.

// File: rtl/sm3x_pkg.sv
package sm3x_pkg;
  localparam int LANE_W = 32;
  localparam int LANES  = 4;
  localparam int BUS_W  = LANE_W * LANES;

  // rotation amounts of the expansion
  localparam int ROT_MIX   = 15;
  localparam int ROT_P1A   = 15;
  localparam int ROT_P1B   = 23;
  localparam int ROT_STEP2 = 7;
  localparam int ROT_FIXA  = 6;
  localparam int ROT_FIXB  = 15;
  localparam int ROT_FIXC  = 30;

  typedef logic [LANE_W-1:0] lane_t;

  typedef struct packed {
    logic capture;    // load the result register this edge
    logic finalStep;  // pick the second-step datapath
  } ctrlStrobe_t;

  function automatic lane_t rotl(input lane_t x, input int n);
    int k;
    k = n % LANE_W;
    if (k == 0) return x;
    return (x << k) | (x >> (LANE_W - k));
  endfunction

  function automatic lane_t permP1(input lane_t x);
    return x ^ rotl(x, ROT_P1A) ^ rotl(x, ROT_P1B);
  endfunction
endpackage

// File: rtl/sm3x_lane.sv
module sm3x_lane
  import sm3x_pkg::*;
#(
  parameter bit HAS_MIX = 1'b1
) (
  input  lane_t aLane,
  input  lane_t bLane,
  input  lane_t cLane,
  output lane_t prelimWord,
  output lane_t finalBase
);
  lane_t mixTerm;

  generate
    if (HAS_MIX) begin : gMix
      assign mixTerm = rotl(bLane, ROT_MIX);
    end else begin : gNoMix
      assign mixTerm = '0;
    end
  endgenerate

  assign prelimWord = permP1(aLane ^ cLane ^ mixTerm);
  assign finalBase  = rotl(bLane, ROT_STEP2) ^ cLane ^ aLane;
endmodule

// File: rtl/sm3x_ctrl.sv
module sm3x_ctrl
  import sm3x_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        op,
  output ctrlStrobe_t strobe,
  output logic        outValid
);
  always_comb begin
    strobe.capture   = inValid;
    strobe.finalStep = op;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/sm3x_datapath.sv
module sm3x_datapath
  import sm3x_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [BUS_W-1:0]  opA,
  input  logic [BUS_W-1:0]  opB,
  input  logic [BUS_W-1:0]  opC,
  output logic [BUS_W-1:0]  result
);
  localparam int TOP = LANES - 1;

  lane_t prelim [LANES];
  lane_t base   [LANES];
  lane_t fixUp;
  logic [BUS_W-1:0] nextResult;

  generate
    for (genvar g = 0; g < LANES; g++) begin : gLane
      sm3x_lane #(.HAS_MIX(g != TOP)) uLane (
        .aLane      (opA[g*LANE_W +: LANE_W]),
        .bLane      (opB[g*LANE_W +: LANE_W]),
        .cLane      (opC[g*LANE_W +: LANE_W]),
        .prelimWord (prelim[g]),
        .finalBase  (base[g])
      );
    end
  endgenerate

  // top lane of the final step folds in the fresh lane-0 word
  assign fixUp = rotl(base[0], ROT_FIXA) ^ rotl(base[0], ROT_FIXB) ^ rotl(base[0], ROT_FIXC);

  always_comb begin
    nextResult = '0;
    for (int i = 0; i < LANES; i++) begin
      if (!strobe.finalStep)
        nextResult[i*LANE_W +: LANE_W] = prelim[i];
      else if (i == TOP)
        nextResult[i*LANE_W +: LANE_W] = base[i] ^ fixUp;
      else
        nextResult[i*LANE_W +: LANE_W] = base[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 result <= '0;
    else if (strobe.capture) result <= nextResult;
  end
endmodule

// File: rtl/sm3_msg_expand.sv
module sm3_msg_expand
  import sm3x_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              op,
  input  logic [BUS_W-1:0]  opA,
  input  logic [BUS_W-1:0]  opB,
  input  logic [BUS_W-1:0]  opC,
  output logic              outValid,
  output logic [BUS_W-1:0]  result
);
  ctrlStrobe_t strobe;

  sm3x_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .op       (op),
    .strobe   (strobe),
    .outValid (outValid)
  );

  sm3x_datapath uData (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .opC    (opC),
    .result (result)
  );
endmodule

// File: rtl/sm3x_checker.sv
module sm3x_checker
  import sm3x_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              op,
  input logic [BUS_W-1:0]  opA,
  input logic [BUS_W-1:0]  opB,
  input logic [BUS_W-1:0]  opC,
  input logic              outValid,
  input logic [BUS_W-1:0]  result
);
  localparam int HI = BUS_W - 1;
  localparam int LO = BUS_W - LANE_W;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!outValid && result == '0));

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  assert_top_prelim_R4: assert property (@(posedge clk) disable iff (rst)
    (inValid && !op) |=>
      result[HI:LO] == permP1($past(opA[HI:LO]) ^ $past(opC[HI:LO])));

  assert_hold_result_R8: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(result));
endmodule

bind sm3_msg_expand sm3x_checker uChk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .op       (op),
  .opA      (opA),
  .opB      (opB),
  .opC      (opC),
  .outValid (outValid),
  .result   (result)
);

// File: tb/tb_sm3_msg_expand.sv
module tb_sm3_msg_expand;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic         op = 1'b0;
  logic [127:0] opA = '0, opB = '0, opC = '0;
  logic         outValid;
  logic [127:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;
  logic [127:0] lastExp = '0;

  logic [127:0] expQ [$];
  string        tagQ [$];

  always #5 clk = ~clk;

  sm3_msg_expand dut (
    .clk(clk), .rst(rst), .inValid(inValid), .op(op),
    .opA(opA), .opB(opB), .opC(opC),
    .outValid(outValid), .result(result)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [31:0] mixP1(input logic [31:0] x);
    return x ^ rl(x, 15) ^ rl(x, 23);
  endfunction

  // reference built from R3, R4, R6, R7
  function automatic logic [127:0] model(input logic s, input logic [127:0] a,
                                         input logic [127:0] b, input logic [127:0] c);
    logic [31:0] w [4];
    logic [127:0] r;
    for (int j = 0; j < 4; j++) begin
      if (!s) begin
        if (j < 3) w[j] = mixP1(a[32*j +: 32] ^ c[32*j +: 32] ^ rl(b[32*j +: 32], 15));
        else       w[j] = mixP1(a[127:96] ^ c[127:96]);
      end else begin
        w[j] = rl(b[32*j +: 32], 7) ^ c[32*j +: 32] ^ a[32*j +: 32];
      end
    end
    if (s) w[3] = w[3] ^ rl(w[0], 6) ^ rl(w[0], 15) ^ rl(w[0], 30);
    r = {w[3], w[2], w[1], w[0]};
    return r;
  endfunction

  function automatic logic [31:0] nextRand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic rnd128(output logic [127:0] v);
    for (int k = 0; k < 4; k++) begin
      seed = nextRand(seed);
      v[32*k +: 32] = seed;
    end
  endtask

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: called at a negedge, issues one request and returns at the next negedge
  task automatic drive(input logic s, input logic [127:0] a, input logic [127:0] b,
                       input logic [127:0] c, input string tag);
    op = s; opA = a; opB = b; opC = c; inValid = 1'b1;
    lastExp = model(s, a, b, c);
    expQ.push_back(lastExp);
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  // idle cycles with moving operands; R8 hold and R2 silence
  task automatic idle(input int n);
    logic [127:0] t;
    inValid = 1'b0;
    for (int k = 0; k < n; k++) begin
      rnd128(t); opA = t; rnd128(t); opB = t; rnd128(t); opC = t;
      op = ~op;
      @(negedge clk);
      check("R8 hold", result, lastExp);
      check("R2 no pulse", {127'd0, outValid}, 128'd0);
    end
  endtask

  // monitor: scoreboard compare
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && outValid) begin
        if (expQ.size() == 0) begin
          check("R2 unexpected pulse", 128'd1, 128'd0);
        end else begin
          string t;
          logic [127:0] e;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(t, result, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] a, b, c;
    repeat (3) @(negedge clk);
    check("R1 outValid", {127'd0, outValid}, 128'd0);
    check("R1 result", result, 128'd0);
    rst = 1'b0;
    @(negedge clk);

    // single-operand patterns, preliminary step (R3, R4)
    drive(1'b0, 128'h00000004_00000003_00000002_00000001, '0, '0, "R3 A only");
    drive(1'b0, '0, 128'h00000000_80000000_00010000_00000001, '0, "R3 B only");
    drive(1'b0, '0, '0, 128'hDEADBEEF_00000000_00000000_00000000, "R4 C top lane");
    idle(2);

    // R5: lane 3 of B must not matter
    rnd128(a); rnd128(b); rnd128(c);
    drive(1'b0, a, b, c, "R5 base");
    drive(1'b0, a, {32'hFFFF_FFFF, b[95:0]}, c, "R5 B3 flipped");
    drive(1'b0, a, {32'h0, b[95:0]}, c, "R5 B3 zero");
    idle(1);

    // final step single-operand patterns (R6, R7)
    drive(1'b1, '0, 128'h00000000_00000001_00000002_00000003, '0, "R6 B only");
    drive(1'b1, 128'h0_0000000_0_0000000_0_0000000_00000001, '0, '0, "R7 lane0 fix-up");
    drive(1'b1, '0, '0, 128'h00000000_00000000_00000000_80000001, "R7 fix-up from C");
    idle(2);

    // random mix, back-to-back (R2, R3, R6, R7)
    for (int n = 0; n < 24; n++) begin
      rnd128(a); rnd128(b); rnd128(c);
      drive(n[0], a, b, c, n[0] ? "R7 random final" : "R3 random prelim");
    end
    idle(3);

    // reset while a result is held (R1)
    rst = 1'b1;
    @(negedge clk);
    check("R1 outValid after run", {127'd0, outValid}, 128'd0);
    check("R1 result after run", result, 128'd0);
    rst = 1'b0;
    lastExp = '0;
    idle(1);

    check("R2 queue drained", {96'd0, 32'(expQ.size())}, 128'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule